// File: doc/BRIEF.md
# Operating-System Timer

This block gives system software a time base and a tick source. A 32-bit stamp counter advances by one on every clock and can be read at any time. Software can also load the counter with any value, and writing zero restarts it. Next to the stamp counter sits a down-counting event timer. It fires after a programmed number of cycles. On each firing it latches a pending flag, and that flag drives the interrupt line.

The event timer is set up through a single reload word. Its two lowest bits are control flags and the bits above them give the count, so every count is a multiple of four. In periodic mode the timer reloads itself on each expiry and keeps running. In one-shot mode it fires once, then stops and drops its enable flag. To shut the timer down, software rewrites the word with enable cleared and the count kept. To resume, it writes the same word again with enable set. The register interface is a single-cycle write strobe with a combinational read path.

Top module: `os_timer`

## Requirements
- R1: While reset is held, the stamp, reload and status reads all return 0, and the pending and interrupt outputs are 0.
- R2: The stamp counter (address 0) advances by exactly 1 per clock. A write to address 0 loads the written value, so writing 0 restarts the count from zero.
- R3: The reload word (address 1) has bit 0 as enable and bit 1 as one-shot. Bits 31:2 give the count, so the count loaded is the written word with bits 1:0 forced to zero. Reading address 1 returns the stored word.
- R4: Any write to the reload word loads the counter at that clock edge. With enable set, the first expiry occurs exactly N clock edges after the write edge, where N is the loaded count. This holds even when a count was already in progress.
- R5: With one-shot clear, each expiry reloads the count, and expiries repeat every N cycles.
- R6: With one-shot set, the timer expires once. It then clears the enable bit of the reload word and raises no further expiries.
- R7: With enable clear, the counter holds and no expiry occurs, and the stored count is kept. Writing 0 to the reload word disables the timer and zeroes it.
- R8: Each expiry sets status bit 0 (address 2). Writing 1 to that bit clears it, and writing 0 leaves it unchanged. An expiry in the same cycle as a clear leaves the bit set.
- R9: The interrupt output and the pending output always equal status bit 0.
- R10: An enabled timer whose loaded count is 0 never expires.
- R11: A read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 2 | Register address: 0 stamp, 1 reload, 2 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pend_o | output | 1 | Pending status bit |
| irq_o | output | 1 | Interrupt request, equal to the pending bit |

## Verification
The bench builds the block with its defaults: a 32-bit data path, two control bits and a two-stage reset synchronizer. With these values the reload counts it uses are small multiples of four, from 4 to 32. Each expiry therefore lands within a few dozen cycles, so exact expiry edges, reloads across two periods, and a clear arriving on the very edge of an expiry can all be observed cycle by cycle. Words with bits 1:0 set show the count masking. Stamp loads near 1000 show that the counter takes arbitrary values.

// File: rtl/ostmr_pkg.sv
package ostmr_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CTRL_W = 2;
  localparam int unsigned EN_BIT = 0;
  localparam int unsigned OS_BIT = 1;

  typedef enum logic [1:0] {
    ADDR_STAMP  = 2'd0,
    ADDR_RELOAD = 2'd1,
    ADDR_STATUS = 2'd2,
    ADDR_SPARE  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/ostmr_rst_sync.sv
module ostmr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/ostmr_stamp.sv
module ostmr_stamp #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] stamp_o
);
  logic [W-1:0] stamp_q;
  logic [W-1:0] stamp_d;

  always_comb begin
    if (ld_i) stamp_d = ld_val_i;
    else      stamp_d = stamp_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stamp_q <= '0;
    else        stamp_q <= stamp_d;
  end

  assign stamp_o = stamp_q;

  assert_stamp_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_i |=> stamp_o == $past(stamp_o) + W'(1));
endmodule

// File: rtl/ostmr_down.sv
module ostmr_down #(
  parameter int unsigned W  = 32,
  parameter int unsigned CW = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cfg_o,
  output logic         expire_o
);
  import ostmr_pkg::*;

  localparam logic [W-1:0] VAL_MASK = {{(W-CW){1'b1}}, {CW{1'b0}}};

  logic [W-1:0] cfg_q, cfg_d;
  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] reload_full;
  logic         cfg_ce, cnt_ce;
  logic         en, one_shot, expire;

  assign reload_full = cfg_q & VAL_MASK;
  assign en          = cfg_q[EN_BIT];
  assign one_shot    = cfg_q[OS_BIT];

  always_comb begin
    cfg_d  = cfg_q;
    cnt_d  = cnt_q;
    cfg_ce = 1'b0;
    cnt_ce = 1'b0;
    expire = 1'b0;
    if (wr_i) begin
      cfg_ce = 1'b1;
      cnt_ce = 1'b1;
      cfg_d  = wdata_i;
      cnt_d  = wdata_i & VAL_MASK;
    end else if (en && (cnt_q != '0)) begin
      cnt_ce = 1'b1;
      if (cnt_q == W'(1)) begin
        expire = 1'b1;
        if (one_shot) begin
          cnt_d         = '0;
          cfg_ce        = 1'b1;
          cfg_d[EN_BIT] = 1'b0;
        end else begin
          cnt_d = reload_full;
        end
      end else begin
        cnt_d = cnt_q - W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      cnt_q <= '0;
    end else begin
      if (cfg_ce) cfg_q <= cfg_d;
      if (cnt_ce) cnt_q <= cnt_d;
    end
  end

  assign cfg_o    = cfg_q;
  assign expire_o = expire;

  assert_hold_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && !en) |=> $stable(cnt_q));

  assert_oneshot_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && one_shot) |=> (!cfg_q[EN_BIT] && cnt_q == '0));

  assert_periodic_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && !one_shot) |=> cnt_q == $past(reload_full));

  assert_zero_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |-> !expire_o);
endmodule

// File: rtl/os_timer.sv
module os_timer #(
  parameter int unsigned DATA_W      = ostmr_pkg::DATA_W,
  parameter int unsigned CTRL_W      = ostmr_pkg::CTRL_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pend_o,
  output logic              irq_o
);
  import ostmr_pkg::*;

  logic              rst_int_n;
  logic [DATA_W-1:0] stamp, cfg;
  logic              expire;
  logic              wr_stamp, wr_reload, wr_status;
  logic              pend_q, pend_d, pend_ce;
  reg_addr_e         addr;

  assign addr      = reg_addr_e'(bus_addr);
  assign wr_stamp  = bus_wr && (addr == ADDR_STAMP);
  assign wr_reload = bus_wr && (addr == ADDR_RELOAD);
  assign wr_status = bus_wr && (addr == ADDR_STATUS);

  ostmr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_int_n)
  );

  ostmr_stamp #(.W(DATA_W)) u_stamp (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ld_i     (wr_stamp),
    .ld_val_i (bus_wdata),
    .stamp_o  (stamp)
  );

  ostmr_down #(.W(DATA_W), .CW(CTRL_W)) u_down (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_i     (wr_reload),
    .wdata_i  (bus_wdata),
    .cfg_o    (cfg),
    .expire_o (expire)
  );

  always_comb begin
    pend_ce = 1'b0;
    pend_d  = pend_q;
    if (expire) begin
      pend_ce = 1'b1;
      pend_d  = 1'b1;
    end else if (wr_status && bus_wdata[0]) begin
      pend_ce = 1'b1;
      pend_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   pend_q <= 1'b0;
    else if (pend_ce) pend_q <= pend_d;
  end

  always_comb begin
    case (addr)
      ADDR_STAMP:  bus_rdata = stamp;
      ADDR_RELOAD: bus_rdata = cfg;
      ADDR_STATUS: bus_rdata = {{(DATA_W-1){1'b0}}, pend_q};
      default:     bus_rdata = '0;
    endcase
  end

  assign pend_o = pend_q;
  assign irq_o  = pend_q;

  assert_pend_cause_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(pend_q) |-> $past(expire));

  assert_pend_clear_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_status && bus_wdata[0] && !expire) |=> !pend_q);

  assert_pend_hold_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!expire && !wr_status) |=> $stable(pend_q));
endmodule

// File: tb/os_timer_tb_top.sv
`timescale 1ns/1ps
module os_timer_tb_top;
  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        pend_o;
  logic        irq_o;

  int errors = 0;
  int checks = 0;

  localparam int NVEC = 7;
  localparam int LIMIT = 64;
  localparam logic [31:0] VEC_WORD [NVEC] = '{32'h9, 32'hB, 32'hF, 32'h7, 32'h18, 32'h1, 32'h13};
  localparam int          VEC_EXP  [NVEC] = '{8, 8, 12, 4, 0, 0, 16};

  os_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pend_o(pend_o), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_pend(input string req, input logic exp);
    chk(req, {31'b0, pend_o}, {31'b0, exp});
    chk("R9 irq", {31'b0, irq_o}, {31'b0, pend_o});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    logic fired;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
    waitn(3);
    // R1 reset state
    rd(2'd0, v); chk("R1 stamp", v, 0);
    rd(2'd1, v); chk("R1 reload", v, 0);
    rd(2'd2, v); chk("R1 status", v, 0);
    chk_pend("R1 pend", 1'b0);
    rst_n = 1'b1;
    waitn(4);

    // Vector table: reload word and expected expiry count (0 = none)
    for (int i = 0; i < NVEC; i++) begin
      wr(2'd1, 32'h0);
      wr(2'd2, 32'h1);
      wr(2'd1, VEC_WORD[i]);
      n = 0; fired = 1'b0;
      for (int c = 0; c < LIMIT; c++) begin
        if (!fired) begin
          @(negedge clk); n++;
          if (pend_o) fired = 1'b1;
        end
      end
      if (VEC_EXP[i] == 0) chk("R7 R10 no expiry", {31'b0, fired}, 32'd0);
      else                 chk("R3 R4 expiry cycles", n, VEC_EXP[i]);
      chk("R9 irq", {31'b0, irq_o}, {31'b0, pend_o});
    end

    // R2 stamp counter
    wr(2'd0, 32'h0); rd(2'd0, v); chk("R2 stamp zero", v, 0);
    waitn(5); rd(2'd0, v); chk("R2 stamp step", v, 5);
    wr(2'd0, 32'd1000); waitn(3); rd(2'd0, v); chk("R2 stamp load", v, 1003);

    // R3 readback
    wr(2'd1, 32'hABCD_0006); rd(2'd1, v); chk("R3 readback", v, 32'hABCD_0006);

    // R5 periodic over two periods, R8 clear semantics
    wr(2'd1, 32'h0); wr(2'd2, 32'h1); wr(2'd1, 32'h9);
    waitn(7); chk_pend("R4 before expiry", 1'b0);
    waitn(1); chk_pend("R5 first expiry", 1'b1);
    wr(2'd2, 32'h1); chk_pend("R8 clear", 1'b0);
    waitn(6); chk_pend("R5 before second", 1'b0);
    waitn(1); chk_pend("R5 second expiry", 1'b1);
    wr(2'd2, 32'h0); chk_pend("R8 write zero kept", 1'b1);

    // R8 clear on the expiry edge loses
    wr(2'd1, 32'h0); wr(2'd2, 32'h1); wr(2'd1, 32'h9);
    waitn(7); wr(2'd2, 32'h1); chk_pend("R8 expiry beats clear", 1'b1);

    // R6 one-shot
    wr(2'd1, 32'h0); wr(2'd2, 32'h1); wr(2'd1, 32'hB);
    waitn(8); chk_pend("R6 oneshot fires", 1'b1);
    rd(2'd1, v); chk("R6 enable cleared", v, 32'hA);
    wr(2'd2, 32'h1); waitn(20); chk_pend("R6 no refire", 1'b0);

    // R7 shutdown then resume
    wr(2'd1, 32'h0); wr(2'd2, 32'h1); wr(2'd1, 32'h11);
    waitn(5); wr(2'd1, 32'h10);
    waitn(30); chk_pend("R7 shutdown silent", 1'b0);
    rd(2'd1, v); chk("R7 count kept", v, 32'h10);
    wr(2'd1, 32'h11);
    waitn(15); chk_pend("R4 resume before", 1'b0);
    waitn(1); chk_pend("R4 resume expiry", 1'b1);

    // R4 rewrite while enabled
    wr(2'd1, 32'h0); wr(2'd2, 32'h1); wr(2'd1, 32'h21);
    waitn(10); wr(2'd1, 32'h9);
    waitn(7); chk_pend("R4 rewrite before", 1'b0);
    waitn(1); chk_pend("R4 rewrite expiry", 1'b1);

    // R7 write zero, R11 spare address
    wr(2'd1, 32'h0); rd(2'd1, v); chk("R7 zero write", v, 0);
    wr(2'd2, 32'h1); waitn(40); chk_pend("R7 zeroed silent", 1'b0);
    rd(2'd3, v); chk("R11 spare read", v, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule